// File: doc/BRIEF.md
# USB Endpoint Buffer State Manager

This block holds the buffer bookkeeping for sixteen USB device endpoints. Index 0 is the control OUT endpoint, index 1 is the control IN endpoint, and indices 2 to 15 are data endpoints 1 to 14. For every endpoint it keeps two buffer-full flags (primary and secondary), a pointer to the buffer the CPU currently owns, a pointer to the buffer the USB side uses next, the next data PID, a stall bit, and setup-received and overwrite markers. Packet payload storage sits elsewhere. This block only decides who owns which buffer and how each token is answered.

The CPU drives one-byte command codes. A validate code hands a filled IN buffer to the USB side. A clear code hands an emptied OUT buffer back to the USB side. A status code returns a snapshot byte and changes nothing. The USB side reports IN tokens, OUT data packets, SETUP packets and host handshakes, and receives an ACK, NAK, STALL or DATA decision one cycle later.

A two-state transaction machine tracks sent IN data:
- In TX_IDLE, an IN token to a stalled endpoint or to an empty buffer leaves the machine in TX_IDLE.
- In TX_IDLE, an IN token to a full buffer answers DATA, latches the endpoint and moves to TX_AWAIT_ACK.
- In TX_AWAIT_ACK, a host handshake retires the latched buffer and returns to TX_IDLE.
- In TX_AWAIT_ACK, any other token drops the pending send, leaves that buffer full and is then handled as in TX_IDLE.

Each endpoint is single-buffered or double-buffered, as set by a static configuration bit.

Top module: `usb_ep_buf_mgr`

## Requirements
- R1: After reset every status byte reads 0x00, and neither cmd_rvalid nor usb_resp_valid is asserted.
- R2: Every command gives cmd_rvalid one cycle later. For codes 0xD0+i (i = 0..15), cmd_rdata is endpoint i's status byte: bit7 stalled, bit6 secondary full, bit5 primary full, bit4 next PID (1 = DATA1), bit3 overwrite, bit2 setup received, bit1 CPU buffer select, bit0 zero. Reading the status byte changes nothing, so a repeated read returns the same byte. For all other codes cmd_rdata is 0x00.
- R3: Code 0x61 (index 1) and codes 0x62..0x6F (indices 2..15) set the full flag of the endpoint's current CPU buffer.
- R4: Code 0x70 (index 0) and codes 0x72..0x7F (indices 2..15) reset the full flag of the current CPU buffer, and they also reset the setup and overwrite bits.
- R5: On a double-buffered endpoint, each validate or clear toggles the CPU buffer select. On a single-buffered endpoint, the CPU buffer select stays 0 and the secondary full flag stays 0.
- R6: An IN token (usb_event 0) is answered one cycle later on usb_resp. The answer is DATA (3) when the buffer that the USB side sends next is full, and NAK (1) otherwise.
- R7: A host handshake (usb_event 3) after a DATA answer clears the full flag of the buffer that was sent and toggles the PID. A handshake with no pending send has no effect. A token that arrives before the handshake leaves the buffer full. A handshake gives no response.
- R8: An OUT packet (usb_event 1) to a free USB-side buffer is answered ACK (0), sets that buffer's full flag and toggles the PID. An OUT packet to a full buffer is answered NAK and changes nothing.
- R9: On a double-buffered endpoint, the USB side keeps its own buffer pointer, starting at primary. The pointer alternates primary and secondary on each retired IN buffer and on each accepted OUT packet.
- R10: While stalled (stall_wr with stall_val 1), every IN, OUT and SETUP token is answered STALL (2) and no buffer flag changes. Writing stall_val 0 unstalls the endpoint and resets the PID to DATA0.
- R11: A SETUP packet (usb_event 2) to an unstalled endpoint is answered ACK. It sets the USB-side buffer full and the setup bit, and it sets the next PID to DATA1. If that buffer was already full, it also sets the overwrite bit.
- R12: Codes outside the defined ranges, including 0x60 and 0x71, change no state and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbuf_en | input | 16 | Per-endpoint double-buffer enable, static |
| cmd_valid | input | 1 | CPU command strobe |
| cmd_code | input | 8 | CPU command code |
| cmd_rvalid | output | 1 | Command result valid, one cycle after the command |
| cmd_rdata | output | 8 | Status byte or 0x00 |
| usb_valid | input | 1 | USB event strobe |
| usb_event | input | 2 | 0 IN token, 1 OUT packet, 2 SETUP packet, 3 host handshake |
| usb_ep | input | 4 | Endpoint index of the event |
| usb_resp_valid | output | 1 | Token decision valid |
| usb_resp | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| stall_wr | input | 1 | Stall sideband write strobe |
| stall_ep | input | 4 | Endpoint index for the stall write |
| stall_val | input | 1 | New stall value |

## Verification
The bench builds the block with its default parameters: sixteen endpoints and the standard validate, clear and status code bases. It sets dbuf_en to 0x000C, so indices 2 and 3 are double-buffered and all other endpoints are single-buffered. With this setting both pointer rotations can be tested (IN on index 2, OUT on index 3), next to single-buffer IN, OUT and SETUP traffic on the control indices and stall behaviour on index 5. The excluded codes 0x60 and 0x71 lie next to live endpoints whose state would visibly change if either code were decoded.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    typedef enum logic [1:0] {
        EV_IN_TOKEN  = 2'd0,
        EV_OUT_PKT   = 2'd1,
        EV_SETUP_PKT = 2'd2,
        EV_HOST_ACK  = 2'd3
    } usb_ev_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_DATA  = 2'd3
    } usb_rsp_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_VALIDATE,
        CMD_CLEAR,
        CMD_STATUS
    } cmd_op_e;

    typedef enum logic {
        TX_IDLE,
        TX_AWAIT_ACK
    } txn_state_e;

    // Field order is the status byte layout, bit 7 first.
    typedef struct packed {
        logic stalled;
        logic full_sec;
        logic full_pri;
        logic pid;
        logic overwrite;
        logic setup;
        logic cpu_sel;
        logic rsvd;
    } ep_status_t;

endpackage

// File: rtl/usb_ep_cmd_dec.sv
module usb_ep_cmd_dec
    import usb_ep_pkg::*;
#(
    parameter int              NUM_EP   = 16,
    parameter int              IDX_W    = 4,
    parameter int              CODE_W   = 8,
    parameter logic [CODE_W-1:0] VAL_BASE = 8'h60,
    parameter logic [CODE_W-1:0] CLR_BASE = 8'h70,
    parameter logic [CODE_W-1:0] STS_BASE = 8'hD0,
    parameter int              VAL_SKIP = 0,
    parameter int              CLR_SKIP = 1
) (
    input  logic [CODE_W-1:0] cmd_code,
    output cmd_op_e           op,
    output logic [IDX_W-1:0]  idx
);

    localparam int HI_W = CODE_W - IDX_W;

    logic [HI_W-1:0] hi;
    logic            in_range;

    assign hi       = cmd_code[CODE_W-1:IDX_W];
    assign idx      = cmd_code[IDX_W-1:0];
    assign in_range = (int'(idx) < NUM_EP);

    always_comb begin
        op = CMD_NONE;
        if (in_range) begin
            if (hi == VAL_BASE[CODE_W-1:IDX_W] && idx != IDX_W'(VAL_SKIP)) begin
                op = CMD_VALIDATE;
            end else if (hi == CLR_BASE[CODE_W-1:IDX_W] && idx != IDX_W'(CLR_SKIP)) begin
                op = CMD_CLEAR;
            end else if (hi == STS_BASE[CODE_W-1:IDX_W]) begin
                op = CMD_STATUS;
            end
        end
    end

endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
    import usb_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbuf,
    input  logic       cpu_validate,
    input  logic       cpu_clear,
    input  logic       usb_in_done,
    input  logic       usb_out_rx,
    input  logic       usb_setup_rx,
    input  logic       stall_wr,
    input  logic       stall_val,
    output ep_status_t status,
    output logic       usb_full,
    output logic       stalled
);

    logic [1:0] full_q,  full_n;
    logic       cpu_q,   cpu_n;
    logic       usbp_q,  usbp_n;
    logic       pid_q,   pid_n;
    logic       ovw_q,   ovw_n;
    logic       setup_q, setup_n;
    logic       stall_q, stall_n;
    logic       u_sel;
    logic       c_sel;

    assign u_sel = dbuf ? usbp_q : 1'b0;
    assign c_sel = dbuf ? cpu_q  : 1'b0;

    // USB-side effects first, CPU-side after, stall sideband last.
    always_comb begin
        full_n  = full_q;
        cpu_n   = cpu_q;
        usbp_n  = usbp_q;
        pid_n   = pid_q;
        ovw_n   = ovw_q;
        setup_n = setup_q;
        stall_n = stall_q;

        if (usb_in_done) begin
            full_n[u_sel] = 1'b0;
            pid_n         = ~pid_q;
            if (dbuf) usbp_n = ~usbp_q;
        end
        if (usb_out_rx) begin
            full_n[u_sel] = 1'b1;
            pid_n         = ~pid_q;
            if (dbuf) usbp_n = ~usbp_q;
        end
        if (usb_setup_rx) begin
            if (full_q[u_sel]) begin
                ovw_n = 1'b1;
            end else if (dbuf) begin
                usbp_n = ~usbp_q;
            end
            full_n[u_sel] = 1'b1;
            setup_n       = 1'b1;
            pid_n         = 1'b1;
        end

        if (cpu_validate) begin
            full_n[c_sel] = 1'b1;
            if (dbuf) cpu_n = ~cpu_q;
        end
        if (cpu_clear) begin
            full_n[c_sel] = 1'b0;
            setup_n       = 1'b0;
            ovw_n         = 1'b0;
            if (dbuf) cpu_n = ~cpu_q;
        end

        if (stall_wr) begin
            stall_n = stall_val;
            if (!stall_val) pid_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 2'b00;
            cpu_q   <= 1'b0;
            usbp_q  <= 1'b0;
            pid_q   <= 1'b0;
            ovw_q   <= 1'b0;
            setup_q <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            full_q  <= full_n;
            cpu_q   <= cpu_n;
            usbp_q  <= usbp_n;
            pid_q   <= pid_n;
            ovw_q   <= ovw_n;
            setup_q <= setup_n;
            stall_q <= stall_n;
        end
    end

    always_comb begin
        status.stalled   = stall_q;
        status.full_sec  = full_q[1];
        status.full_pri  = full_q[0];
        status.pid       = pid_q;
        status.overwrite = ovw_q;
        status.setup     = setup_q;
        status.cpu_sel   = cpu_q;
        status.rsvd      = 1'b0;
    end

    assign usb_full = full_q[u_sel];
    assign stalled  = stall_q;

endmodule

// File: rtl/usb_ep_txn_fsm.sv
module usb_ep_txn_fsm
    import usb_ep_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_valid,
    input  usb_ev_e          usb_event,
    input  logic [IDX_W-1:0] usb_ep,
    input  logic             tgt_stalled,
    input  logic             tgt_full,
    output logic             in_done,
    output logic             out_rx,
    output logic             setup_rx,
    output logic [IDX_W-1:0] act_ep,
    output logic             resp_valid,
    output usb_rsp_e         resp
);

    txn_state_e       state, state_n;
    logic [IDX_W-1:0] pend_ep, pend_ep_n;
    logic             rsp_v_n;
    usb_rsp_e         rsp_n;
    logic             is_ack;
    logic             is_tok;

    assign is_ack = usb_valid && (usb_event == EV_HOST_ACK);
    assign is_tok = usb_valid && (usb_event != EV_HOST_ACK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            pend_ep    <= '0;
            resp_valid <= 1'b0;
            resp       <= RSP_ACK;
        end else begin
            state      <= state_n;
            pend_ep    <= pend_ep_n;
            resp_valid <= rsp_v_n;
            resp       <= rsp_n;
        end
    end

    always_comb begin
        state_n   = state;
        pend_ep_n = pend_ep;
        in_done   = 1'b0;
        out_rx    = 1'b0;
        setup_rx  = 1'b0;
        act_ep    = usb_ep;
        rsp_v_n   = 1'b0;
        rsp_n     = RSP_NAK;

        unique case (state)
            TX_IDLE: begin
                state_n = TX_IDLE;
            end
            TX_AWAIT_ACK: begin
                if (is_ack) begin
                    in_done = 1'b1;
                    act_ep  = pend_ep;
                    state_n = TX_IDLE;
                end else if (is_tok) begin
                    state_n = TX_IDLE;
                end
            end
        endcase

        if (is_tok) begin
            rsp_v_n = 1'b1;
            if (tgt_stalled) begin
                rsp_n = RSP_STALL;
            end else begin
                unique case (usb_event)
                    EV_IN_TOKEN: begin
                        if (tgt_full) begin
                            rsp_n     = RSP_DATA;
                            state_n   = TX_AWAIT_ACK;
                            pend_ep_n = usb_ep;
                        end else begin
                            rsp_n = RSP_NAK;
                        end
                    end
                    EV_OUT_PKT: begin
                        if (tgt_full) begin
                            rsp_n = RSP_NAK;
                        end else begin
                            rsp_n  = RSP_ACK;
                            out_rx = 1'b1;
                        end
                    end
                    EV_SETUP_PKT: begin
                        rsp_n    = RSP_ACK;
                        setup_rx = 1'b1;
                    end
                    EV_HOST_ACK: begin
                        rsp_n = RSP_NAK;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usb_ep_buf_mgr.sv
module usb_ep_buf_mgr
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EP-1:0]         dbuf_en,
    input  logic                      cmd_valid,
    input  logic [7:0]                cmd_code,
    output logic                      cmd_rvalid,
    output logic [7:0]                cmd_rdata,
    input  logic                      usb_valid,
    input  logic [1:0]                usb_event,
    input  logic [$clog2(NUM_EP)-1:0] usb_ep,
    output logic                      usb_resp_valid,
    output logic [1:0]                usb_resp,
    input  logic                      stall_wr,
    input  logic [$clog2(NUM_EP)-1:0] stall_ep,
    input  logic                      stall_val
);

    localparam int IDX_W = $clog2(NUM_EP);

    cmd_op_e          dec_op;
    logic [IDX_W-1:0] dec_idx;

    ep_status_t       st [NUM_EP];
    logic [NUM_EP-1:0] usb_full_v;
    logic [NUM_EP-1:0] stall_v;
    logic [NUM_EP-1:0] sel_v;
    logic [NUM_EP-1:0] full2_v;

    logic             in_done, out_rx, setup_rx;
    logic [IDX_W-1:0] act_ep;
    usb_rsp_e         rsp;

    usb_ep_cmd_dec #(
        .NUM_EP (NUM_EP),
        .IDX_W  (IDX_W)
    ) u_dec (
        .cmd_code (cmd_code),
        .op       (dec_op),
        .idx      (dec_idx)
    );

    usb_ep_txn_fsm #(
        .IDX_W (IDX_W)
    ) u_txn (
        .clk         (clk),
        .rst_n       (rst_n),
        .usb_valid   (usb_valid),
        .usb_event   (usb_ev_e'(usb_event)),
        .usb_ep      (usb_ep),
        .tgt_stalled (stall_v[usb_ep]),
        .tgt_full    (usb_full_v[usb_ep]),
        .in_done     (in_done),
        .out_rx      (out_rx),
        .setup_rx    (setup_rx),
        .act_ep      (act_ep),
        .resp_valid  (usb_resp_valid),
        .resp        (rsp)
    );

    assign usb_resp = rsp;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic hit_cmd, hit_usb, hit_stall;
        assign hit_cmd   = cmd_valid && (dec_idx == IDX_W'(g));
        assign hit_usb   = (act_ep == IDX_W'(g));
        assign hit_stall = stall_wr && (stall_ep == IDX_W'(g));

        usb_ep_slot u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .dbuf         (dbuf_en[g]),
            .cpu_validate (hit_cmd && dec_op == CMD_VALIDATE),
            .cpu_clear    (hit_cmd && dec_op == CMD_CLEAR),
            .usb_in_done  (hit_usb && in_done),
            .usb_out_rx   (hit_usb && out_rx),
            .usb_setup_rx (hit_usb && setup_rx),
            .stall_wr     (hit_stall),
            .stall_val    (stall_val),
            .status       (st[g]),
            .usb_full     (usb_full_v[g]),
            .stalled      (stall_v[g])
        );

        assign sel_v[g]   = st[g].cpu_sel;
        assign full2_v[g] = st[g].full_sec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_rvalid <= 1'b0;
            cmd_rdata  <= 8'h00;
        end else begin
            cmd_rvalid <= cmd_valid;
            if (cmd_valid) begin
                cmd_rdata <= (dec_op == CMD_STATUS) ? st[dec_idx] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/usb_ep_buf_mgr_chk.sv
module usb_ep_buf_mgr_chk #(
    parameter int NUM_EP = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_hi,
    input logic              cmd_rvalid,
    input logic [7:0]        cmd_rdata,
    input logic              usb_valid,
    input logic [1:0]        usb_event,
    input logic [IDX_W-1:0]  usb_ep,
    input logic              usb_resp_valid,
    input logic [1:0]        usb_resp,
    input logic [NUM_EP-1:0] dbuf_en,
    input logic [NUM_EP-1:0] sel_v,
    input logic [NUM_EP-1:0] full2_v,
    input logic [NUM_EP-1:0] stall_v
);

    // R2
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_rvalid);

    // R2
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_rvalid);

    // R12
    nonstatus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_hi != 4'hD) |=> (cmd_rdata == 8'h00));

    // R6
    token_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_valid && usb_event != 2'd3) |=> usb_resp_valid);

    // R7
    handshake_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!usb_valid || usb_event == 2'd3) |=> !usb_resp_valid);

    // R10
    stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_valid && usb_event != 2'd3 && stall_v[usb_ep]) |=> (usb_resp == 2'd2));

    // R5
    single_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_v | full2_v) & ~dbuf_en) == '0);

endmodule

bind usb_ep_buf_mgr usb_ep_buf_mgr_chk #(
    .NUM_EP (NUM_EP),
    .IDX_W  ($clog2(NUM_EP))
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_hi         (cmd_code[7:4]),
    .cmd_rvalid     (cmd_rvalid),
    .cmd_rdata      (cmd_rdata),
    .usb_valid      (usb_valid),
    .usb_event      (usb_event),
    .usb_ep         (usb_ep),
    .usb_resp_valid (usb_resp_valid),
    .usb_resp       (usb_resp),
    .dbuf_en        (dbuf_en),
    .sel_v          (sel_v),
    .full2_v        (full2_v),
    .stall_v        (stall_v)
);

// File: tb/tb_usb_ep_buf_mgr.sv
`timescale 1ns/1ps
module tb_usb_ep_buf_mgr;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] dbuf_en;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        cmd_rvalid;
    logic [7:0]  cmd_rdata;
    logic        usb_valid;
    logic [1:0]  usb_event;
    logic [3:0]  usb_ep;
    logic        usb_resp_valid;
    logic [1:0]  usb_resp;
    logic        stall_wr;
    logic [3:0]  stall_ep;
    logic        stall_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [1:0] rsp_exp_q[$];
    string      rsp_tag_q[$];

    always #4 clk = ~clk;

    usb_ep_buf_mgr dut (
        .clk(clk), .rst_n(rst_n), .dbuf_en(dbuf_en),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_rvalid(cmd_rvalid), .cmd_rdata(cmd_rdata),
        .usb_valid(usb_valid), .usb_event(usb_event), .usb_ep(usb_ep),
        .usb_resp_valid(usb_resp_valid), .usb_resp(usb_resp),
        .stall_wr(stall_wr), .stall_ep(stall_ep), .stall_val(stall_val)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] code, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ev(input logic [1:0] e, input logic [3:0] ep, input logic [1:0] exp, input string tag);
        @(negedge clk);
        usb_valid = 1'b1;
        usb_event = e;
        usb_ep    = ep;
        if (e != 2'd3) begin
            rsp_exp_q.push_back(exp);
            rsp_tag_q.push_back(tag);
        end
        @(negedge clk);
        usb_valid = 1'b0;
    endtask

    task automatic stall(input logic [3:0] ep, input logic v);
        @(negedge clk);
        stall_wr  = 1'b1;
        stall_ep  = ep;
        stall_val = v;
        @(negedge clk);
        stall_wr  = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmd_rvalid) begin
                if (rd_exp_q.size() == 0) begin
                    check("R2 unexpected cmd_rvalid", 8'h01, 8'h00);
                end else begin
                    check(rd_tag_q.pop_front(), cmd_rdata, rd_exp_q.pop_front());
                end
            end
            if (usb_resp_valid) begin
                if (rsp_exp_q.size() == 0) begin
                    check("R7 unexpected usb_resp_valid", 8'h01, 8'h00);
                end else begin
                    check(rsp_tag_q.pop_front(), {6'd0, usb_resp}, {6'd0, rsp_exp_q.pop_front()});
                end
            end
        end
    end

    task automatic finish_up;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; dbuf_en = 16'h000C;
        cmd_valid = 1'b0; cmd_code = 8'h00;
        usb_valid = 1'b0; usb_event = 2'd0; usb_ep = 4'd0;
        stall_wr = 1'b0; stall_ep = 4'd0; stall_val = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid idle", {7'd0, cmd_rvalid}, 8'h00);
        check("R1 resp idle", {7'd0, usb_resp_valid}, 8'h00);
        cmd(8'hD0, 8'h00, "R1 status ep0");
        cmd(8'hD1, 8'h00, "R1 status ep1");
        cmd(8'hD5, 8'h00, "R1 status ep5");
        cmd(8'hDF, 8'h00, "R1 status ep15");

        // Single-buffer IN on index 1
        ev(2'd0, 4'd1, 2'd1, "R6 IN empty NAK");
        cmd(8'h61, 8'h00, "R3 validate rdata");
        cmd(8'hD1, 8'h20, "R3 primary full");
        cmd(8'hD1, 8'h20, "R2 repeat read unchanged");
        cmd(8'h61, 8'h00, "R5 second validate rdata");
        cmd(8'hD1, 8'h20, "R5 single no secondary");
        ev(2'd0, 4'd1, 2'd3, "R6 IN full DATA");
        ev(2'd3, 4'd1, 2'd0, "R7 ack");
        cmd(8'hD1, 8'h10, "R7 retired pid toggled");
        ev(2'd0, 4'd1, 2'd1, "R6 IN after retire NAK");
        ev(2'd3, 4'd1, 2'd0, "R7 stray ack");
        cmd(8'hD1, 8'h10, "R7 stray ack no effect");

        // Lost handshake then retry
        cmd(8'h61, 8'h00, "R3 validate rdata");
        ev(2'd0, 4'd1, 2'd3, "R7 first send DATA");
        cmd(8'hD1, 8'h30, "R7 still full while pending");
        ev(2'd0, 4'd1, 2'd3, "R7 resend DATA");
        ev(2'd3, 4'd1, 2'd0, "R7 ack");
        cmd(8'hD1, 8'h00, "R7 retired after retry");

        // Single-buffer OUT on index 0
        ev(2'd1, 4'd0, 2'd0, "R8 OUT ACK");
        cmd(8'hD0, 8'h30, "R8 full pid toggled");
        ev(2'd1, 4'd0, 2'd1, "R8 OUT full NAK");
        cmd(8'hD0, 8'h30, "R8 NAK no change");
        cmd(8'h70, 8'h00, "R4 clear rdata");
        cmd(8'hD0, 8'h10, "R4 cleared");
        ev(2'd1, 4'd0, 2'd0, "R8 OUT ACK again");
        cmd(8'hD0, 8'h20, "R8 pid back to DATA0");
        cmd(8'h70, 8'h00, "R4 clear rdata");
        cmd(8'hD0, 8'h00, "R4 cleared");

        // Double-buffer IN on index 2
        cmd(8'h62, 8'h00, "R3 validate rdata");
        cmd(8'hD2, 8'h22, "R5 cpu sel toggled");
        cmd(8'h62, 8'h00, "R3 validate rdata");
        cmd(8'hD2, 8'h60, "R5 both full sel back");
        ev(2'd0, 4'd2, 2'd3, "R9 send primary");
        ev(2'd3, 4'd2, 2'd0, "R9 ack");
        cmd(8'hD2, 8'h50, "R9 primary retired");
        ev(2'd0, 4'd2, 2'd3, "R9 send secondary");
        ev(2'd3, 4'd2, 2'd0, "R9 ack");
        cmd(8'hD2, 8'h00, "R9 secondary retired");
        ev(2'd0, 4'd2, 2'd1, "R6 IN empty NAK");

        // Double-buffer OUT on index 3
        ev(2'd1, 4'd3, 2'd0, "R9 OUT primary");
        cmd(8'hD3, 8'h30, "R9 primary filled");
        ev(2'd1, 4'd3, 2'd0, "R9 OUT secondary");
        cmd(8'hD3, 8'h60, "R9 both filled");
        ev(2'd1, 4'd3, 2'd1, "R8 OUT both full NAK");
        cmd(8'hD3, 8'h60, "R8 NAK no change");
        cmd(8'h73, 8'h00, "R4 clear rdata");
        cmd(8'hD3, 8'h42, "R5 clear toggles sel");
        ev(2'd1, 4'd3, 2'd0, "R9 OUT primary again");
        cmd(8'hD3, 8'h72, "R9 refilled primary");
        cmd(8'h73, 8'h00, "R4 clear rdata");
        cmd(8'hD3, 8'h30, "R5 clear secondary");

        // Stall on index 5
        ev(2'd1, 4'd5, 2'd0, "R8 OUT ACK");
        cmd(8'h75, 8'h00, "R4 clear rdata");
        cmd(8'hD5, 8'h10, "R4 cleared pid1");
        stall(4'd5, 1'b1);
        cmd(8'hD5, 8'h90, "R10 stall bit");
        ev(2'd0, 4'd5, 2'd2, "R10 IN STALL");
        ev(2'd1, 4'd5, 2'd2, "R10 OUT STALL");
        ev(2'd2, 4'd5, 2'd2, "R10 SETUP STALL");
        cmd(8'hD5, 8'h90, "R10 flags unchanged");
        stall(4'd5, 1'b0);
        cmd(8'hD5, 8'h00, "R10 unstall pid reset");

        // SETUP on index 0
        ev(2'd2, 4'd0, 2'd0, "R11 SETUP ACK");
        cmd(8'hD0, 8'h34, "R11 setup full DATA1");
        ev(2'd2, 4'd0, 2'd0, "R11 SETUP over full ACK");
        cmd(8'hD0, 8'h3C, "R11 overwrite set");
        ev(2'd1, 4'd0, 2'd1, "R8 OUT full NAK");
        cmd(8'h70, 8'h00, "R4 clear rdata");
        cmd(8'hD0, 8'h10, "R4 clears setup and overwrite");

        // Undefined codes
        cmd(8'h61, 8'h00, "R3 validate rdata");
        cmd(8'h71, 8'h00, "R12 0x71 returns zero");
        cmd(8'hD1, 8'h20, "R12 0x71 no clear");
        cmd(8'h60, 8'h00, "R12 0x60 returns zero");
        cmd(8'hD0, 8'h10, "R12 0x60 no validate");
        cmd(8'h55, 8'h00, "R12 0x55 returns zero");
        cmd(8'hE3, 8'h00, "R12 0xE3 returns zero");
        cmd(8'hD3, 8'h30, "R12 state kept");

        repeat (4) @(negedge clk);
        check("R2 all reads seen", 8'(rd_exp_q.size()), 8'h00);
        check("R6 all responses seen", 8'(rsp_exp_q.size()), 8'h00);
        finish_up();
    end

endmodule